// File: doc/BRIEF.md
# Configuration Memory Security Controller

This block sits in front of a small configuration store and decides, command by command, whether a request may touch that store. A requester presents an opcode with an address and a data word on a valid/ready handshake. The controller reports exactly one status, done or rejected, on the cycle after it takes the command. Two protection flags are kept: a read lock and a write lock. Together they form four protection settings, and the settings are visible on an output.

The store is modelled as a register array so that the effect of each command can be observed. Erasing drives every word to all ones. Programming can only pull bits from one to zero. Readback returns a word with its status.

The read lock hides the contents and also forbids programming. The whole-array erase stays permitted under the read lock, and that erase is the only way the read lock is released. The write lock forbids erasing and programming, and a dedicated command lifts it so that a fresh image can be loaded. A rejected command changes nothing.

Top module: `cfg_guard`

## Requirements
- R1: After reset both protection flags are clear (`lock_state` = 2'b00), no response is shown, `cmd_ready` is high, and every memory word reads back as all ones.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. On the next cycle `rsp_valid` is high, `cmd_ready` is low and `rsp_status` is 2'b01 (done) or 2'b10 (rejected). When no response is pending, `rsp_status` is 2'b00 and `rsp_valid` is low.
- R3: Erase (opcode 3'd0) with the write lock clear sets every word to all ones, clears the read lock and reports done.
- R4: Program (opcode 3'd1) with both flags clear replaces the addressed word with the bitwise AND of the word and `cmd_wdata`, so no bit goes from 0 to 1, and it reports done.
- R5: Readback (opcode 3'd2) with the read lock clear reports done and returns the addressed word on `rsp_rdata`. Every other response carries `rsp_rdata` = 0.
- R6: With the read lock set, readback and program are rejected and erase is still performed.
- R7: No command other than an accepted erase clears the read lock. The read-lock set command (opcode 3'd3) sets it.
- R8: With the write lock set, erase and program are rejected.
- R9: Opcode 3'd4 sets the write lock and opcode 3'd5 clears it, whatever the flags are. Both report done, and after the write lock is cleared, programming proceeds when the read lock is clear.
- R10: A rejected command leaves the memory and both flags unchanged. Opcodes 3'd6 and 3'd7 are always rejected.
- R11: `lock_state` bit 0 is the read lock and bit 1 is the write lock, so the four values 00, 01, 10 and 11 name the four protection settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The controller can take a command this cycle |
| cmd_op | input | 3 | Opcode (0 erase, 1 program, 2 readback, 3 set read lock, 4 set write lock, 5 clear write lock) |
| cmd_addr | input | AW | Word address for program and readback |
| cmd_wdata | input | WIDTH | Program data, ANDed into the word |
| rsp_valid | output | 1 | A response is shown |
| rsp_status | output | 2 | 01 done, 10 rejected, 00 idle |
| rsp_rdata | output | WIDTH | Readback word, zero otherwise |
| lock_state | output | 2 | {write lock, read lock} |

## Verification
Every opcode, including the two unused ones, is applied under each of the four protection settings after the array has been filled with an address-dependent pattern and then programmed a second time. This separates AND-merging from overwriting and tells each permission rule apart from its neighbours. After each command, whenever the read lock is clear, the whole array is read back to show whether the command touched memory it should not have. A directed sequence locks, unlocks and programs again to tell a removable write lock from a sticky one.

// File: rtl/cfg_guard_pkg.sv
// Package: shared opcodes, status codes and the decoded action record
// for the configuration memory security controller.
// Assumes a 3-bit opcode field; unused opcode values are legal inputs.
package cfg_guard_pkg;

    localparam logic [2:0] OP_ERASE     = 3'd0;
    localparam logic [2:0] OP_PROGRAM   = 3'd1;
    localparam logic [2:0] OP_READ      = 3'd2;
    localparam logic [2:0] OP_LOCK_RD   = 3'd3;
    localparam logic [2:0] OP_LOCK_WR   = 3'd4;
    localparam logic [2:0] OP_UNLOCK_WR = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_DONE   = 2'b01,
        ST_REJECT = 2'b10
    } status_t;

    typedef struct packed {
        logic permit;
        logic do_erase;
        logic do_prog;
        logic do_read;
        logic set_rd;
        logic set_wr;
        logic clr_wr;
    } action_t;

endpackage

// File: rtl/cfg_policy.sv
// Module: cfg_policy
// Pure combinational permission check. Given an opcode and the two
// protection flags, it says whether the command is permitted and which
// side effects it has. Side-effect bits are only raised for permitted
// commands, so callers qualify them with the accept strobe alone.
module cfg_policy
    import cfg_guard_pkg::*;
(
    input  logic [2:0] op,
    input  logic       rd_lock,
    input  logic       wr_lock,
    output action_t    act
);

    // Decode opcode against the current protection setting.
    always_comb begin
        act = '0;
        unique case (op)
            OP_ERASE: begin
                act.do_erase = !wr_lock;
                act.permit   = !wr_lock;
            end
            OP_PROGRAM: begin
                act.do_prog = !wr_lock && !rd_lock;
                act.permit  = !wr_lock && !rd_lock;
            end
            OP_READ: begin
                act.do_read = !rd_lock;
                act.permit  = !rd_lock;
            end
            OP_LOCK_RD: begin
                act.set_rd = 1'b1;
                act.permit = 1'b1;
            end
            OP_LOCK_WR: begin
                act.set_wr = 1'b1;
                act.permit = 1'b1;
            end
            OP_UNLOCK_WR: begin
                act.clr_wr = 1'b1;
                act.permit = 1'b1;
            end
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/cfg_array.sv
// Module: cfg_array
// Register model of the configuration store. Reset and erase both drive
// every word to all ones; a program strobe ANDs data into one word, so bits
// can only fall. Read is combinational from the address.
// Assumes erase and program are never raised together.
module cfg_array #(
    parameter  int WORDS = 8,
    parameter  int WIDTH = 8,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase,
    input  logic             prog,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [WORDS-1:0]            hit;

    // Per-word address decode for the program strobe.
    for (genvar i = 0; i < WORDS; i++) begin : g_hit
        assign hit[i] = prog && (addr == AW'(i));
    end

    // Store update: reset/erase fill with ones, program clears bits.
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (!rst_n || erase) begin
                words[i] <= '1;
            end else if (hit[i]) begin
                words[i] <= words[i] & wdata;
            end
        end
    end

    assign rdata = words[addr];

endmodule

// File: rtl/cfg_guard.sv
// Module: cfg_guard (top)
// Security front end of the configuration store. It takes one command per
// valid/ready handshake, checks it against the read and write locks, applies
// permitted effects, and returns one status the following cycle. While that
// status is shown, ready is low, so commands are at most one per two cycles.
// Assumes a synchronous active-low reset and a power-of-two WORDS.
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter  int WORDS = 8,
    parameter  int WIDTH = 8,
    localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [WIDTH-1:0] cmd_wdata,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [WIDTH-1:0] rsp_rdata,
    output logic [1:0]       lock_state
);

    action_t          act;
    logic             accept;
    logic             rd_lock_q, wr_lock_q;
    logic             rsp_valid_q;
    status_t          status_q;
    logic [WIDTH-1:0] rdata_q;
    logic [WIDTH-1:0] arr_rdata;

    assign cmd_ready = !rsp_valid_q;
    assign accept    = cmd_valid && cmd_ready;

    cfg_policy u_policy (
        .op      (cmd_op),
        .rd_lock (rd_lock_q),
        .wr_lock (wr_lock_q),
        .act     (act)
    );

    cfg_array #(
        .WORDS (WORDS),
        .WIDTH (WIDTH)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (accept && act.do_erase),
        .prog  (accept && act.do_prog),
        .addr  (cmd_addr),
        .wdata (cmd_wdata),
        .rdata (arr_rdata)
    );

    // Protection flags: only permitted commands move them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lock_q <= 1'b0;
            wr_lock_q <= 1'b0;
        end else if (accept) begin
            if (act.do_erase) rd_lock_q <= 1'b0;
            if (act.set_rd)   rd_lock_q <= 1'b1;
            if (act.set_wr)   wr_lock_q <= 1'b1;
            if (act.clr_wr)   wr_lock_q <= 1'b0;
        end
    end

    // Response register: one status per accepted command, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            status_q    <= ST_IDLE;
            rdata_q     <= '0;
        end else begin
            rsp_valid_q <= accept;
            status_q    <= !accept ? ST_IDLE : (act.permit ? ST_DONE : ST_REJECT);
            rdata_q     <= (accept && act.do_read) ? arr_rdata : '0;
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = status_q;
    assign rsp_rdata  = rdata_q;
    assign lock_state = {wr_lock_q, rd_lock_q};

endmodule

// File: rtl/cfg_guard_chk.sv
// Module: cfg_guard_chk
// Protocol and permission properties for cfg_guard, attached by bind.
// It sees only the top-level ports and relates them across cycles.
module cfg_guard_chk
    import cfg_guard_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [2:0] cmd_op,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic [1:0] lock_state
);

    logic acc;
    assign acc = cmd_valid && cmd_ready;

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_valid && rsp_status != ST_IDLE)); // R2
    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc)); // R2
    AST_BUSY_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R2
    AST_ERASE_FREES_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_ERASE && !lock_state[1]) |=> (!lock_state[0] && rsp_status == ST_DONE)); // R3
    AST_RD_LOCK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cmd_op == OP_READ || cmd_op == OP_PROGRAM) && lock_state[0]) |=> rsp_status == ST_REJECT); // R6
    AST_RD_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_state[0]) |-> $past(acc && cmd_op == OP_ERASE)); // R7
    AST_WR_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (cmd_op == OP_ERASE || cmd_op == OP_PROGRAM) && lock_state[1]) |=> rsp_status == ST_REJECT); // R8
    AST_UNLOCK_WR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == OP_UNLOCK_WR) |=> (!lock_state[1] && rsp_status == ST_DONE)); // R9
    AST_REJECT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == ST_REJECT) |-> $stable(lock_state)); // R10

endmodule

bind cfg_guard cfg_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .lock_state (lock_state)
);

// File: tb/cfg_guard_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every opcode under every protection setting against an
// arithmetic model of the store and the flags.
module cfg_guard_tb;

    localparam int WORDS = 8;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(WORDS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = '0;
    logic [AW-1:0]    cmd_addr = '0;
    logic [WIDTH-1:0] cmd_wdata = '0;
    logic             rsp_valid;
    logic [1:0]       rsp_status;
    logic [WIDTH-1:0] rsp_rdata;
    logic [1:0]       lock_state;

    int vectors = 0;
    int fails   = 0;

    logic [WIDTH-1:0] m_mem [WORDS];
    logic             m_rd, m_wr;

    always #2.5 clk = ~clk;

    cfg_guard #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata),
        .lock_state (lock_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // Synchronous reset for two cycles; model returns to its reset state.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
        m_rd = 1'b0;
        m_wr = 1'b0;
    endtask

    // Issue one command, update the model, check the response cycle.
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        logic             ok;
        logic [WIDTH-1:0] exp_rd;
        string            tag;
        ok = 1'b0;
        exp_rd = '0;
        case (op)
            3'd0: begin tag = m_rd ? "R6" : (m_wr ? "R8" : "R3");
                if (!m_wr) begin ok = 1'b1; m_rd = 1'b0;
                    for (int i = 0; i < WORDS; i++) m_mem[i] = '1; end end
            3'd1: begin tag = m_rd ? "R6" : (m_wr ? "R8" : "R4");
                if (!m_wr && !m_rd) begin ok = 1'b1; m_mem[a] = m_mem[a] & d; end end
            3'd2: begin tag = m_rd ? "R6" : "R5";
                if (!m_rd) begin ok = 1'b1; exp_rd = m_mem[a]; end end
            3'd3: begin tag = "R7"; ok = 1'b1; m_rd = 1'b1; end
            3'd4: begin tag = "R9"; ok = 1'b1; m_wr = 1'b1; end
            3'd5: begin tag = "R9"; ok = 1'b1; m_wr = 1'b0; end
            default: tag = "R10";
        endcase
        cmd_op = op;
        cmd_addr = a;
        cmd_wdata = d;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
        check("R2 cmd_ready low", 32'(cmd_ready), 32'd0);
        check({tag, " status"}, 32'(rsp_status), ok ? 32'd1 : 32'd2);
        check({tag, " rdata R5"}, 32'(rsp_rdata), 32'(exp_rd));
        check({tag, " lock_state R11"}, 32'(lock_state), 32'({m_wr, m_rd}));
        @(negedge clk);
        check("R2 idle status", 32'(rsp_status), 32'd0);
    endtask

    // Read every word back (only meaningful while read lock is clear).
    task automatic read_all();
        for (int i = 0; i < WORDS; i++) issue(3'd2, AW'(i), '0);
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state at the ports and erased contents
        check("R1 lock_state", 32'(lock_state), 32'd0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
        check("R1 rsp_status", 32'(rsp_status), 32'd0);
        read_all();

        // Sweep: every opcode under each of the four protection settings
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 8; op++) begin
                do_reset();
                for (int k = 0; k < WORDS; k++)
                    issue(3'd1, AW'(k), WIDTH'(k * 59 + 150));
                for (int k = 0; k < WORDS; k++)
                    issue(3'd1, AW'(k), WIDTH'(k * 29 + 77)); // R4 AND merge
                if (s[1]) issue(3'd4, '0, '0);
                if (s[0]) issue(3'd3, '0, '0);
                issue(3'(op), AW'(op + s), WIDTH'(8'h5A ^ (op * 17)));
                if (!m_rd) read_all(); // R10: untouched words visible
                // R7: write-lock commands must not drop the read lock
                if (s[0] && op != 0) begin
                    issue(3'd5, '0, '0);
                    issue(3'd4, '0, '0);
                end
            end
        end

        // R9: removable write lock, then reprogramming proceeds
        do_reset();
        issue(3'd4, '0, '0);
        issue(3'd1, 3'd2, 8'h0F);
        issue(3'd0, '0, '0);
        issue(3'd5, '0, '0);
        issue(3'd1, 3'd2, 8'h0F);
        issue(3'd2, 3'd2, '0);
        // R3/R6: erase under read lock releases it, then readback works
        issue(3'd3, '0, '0);
        issue(3'd2, 3'd2, '0);
        issue(3'd0, '0, '0);
        read_all();

        summary();
        $finish;
    end

endmodule